// File: doc/BRIEF.md
# Virtual Channel Transmit Arbiter

This block is the transmit-side traffic manager of a single serial link. Packet descriptors arrive tagged with a virtual-channel number. Each of the nine channels has its own queue and its own link-level credit counter. On every cycle in which the link can take a packet, a weighted round-robin scheduler picks one eligible channel. The descriptor at that channel's send position is then presented on the output for one cycle.

Channels carry one of two traffic classes. On a reliable channel a sent packet stays in the queue until an acknowledge frees it. A retry rewinds the channel so that every unacknowledged packet is sent again, oldest first, before any newer one. On a continuous channel a packet is gone once it is sent, and acknowledges and retries have no effect. When a continuous queue is full, a new arrival replaces the oldest waiting entry and is counted as a drop.

Packets within one channel leave in order. Packets on different channels have no order relative to each other. Channel 0 is always reliable.

Top module: `vc_tx_arbiter`

## Requirements
- R1: Each channel v (0..8) owns a FIFO. A push with in_valid_i high and in_vc_i = v enqueues in_desc_i there, and packets of one channel are granted in arrival order. Packets on different channels are ordered only by the scheduler.
- R2: A grant decided in a cycle with link_ready_i high appears on out_valid_o, out_vc_o and out_desc_o in the next cycle, and out_valid_o is high for exactly that one cycle. With link_ready_i low, or with no eligible channel, out_valid_o is low in the next cycle.
- R3: A channel is eligible only if it holds an entry not yet sent and its credit counter is nonzero. Each grant takes one credit. A high bit v of credit_ret_i adds one credit to channel v, saturating at the counter maximum. After reset each counter holds INIT_CREDIT (default 4).
- R4: Scheduling is weighted round-robin. The 4-bit weight of channel v is weight_i[4v+3:4v], and a weight of 0 counts as 1. The scheduler searches upward from its pointer, wrapping from 8 to 0, and takes the first eligible channel. It stays on a channel until that channel has had weight-many grants in a row, then moves the pointer past it.
- R5: cont_mode_i[v] = 1 makes channel v (1..8) continuous and 0 makes it reliable. cont_mode_i[0] is ignored, so channel 0 is always reliable.
- R6: On a reliable channel a granted packet stays queued. ack_i with ack_vc_i = v frees the oldest sent entry. An ack to a channel with no sent entry has no effect.
- R7: retry_i with retry_vc_i = v on a reliable channel that has sent entries re-presents all of them, oldest first, ahead of newer packets, and raises retx_cnt_o field v by one. That channel is not granted in the retry cycle.
- R8: On a continuous channel a granted packet is removed at once. ack_i and retry_i aimed at it have no effect, and its retransmit count stays 0.
- R9: A push to a full continuous channel with no grant in the same cycle discards that channel's oldest entry, stores the new one, and raises drop_cnt_o field v by one.
- R10: A reliable queue is full when it holds DEPTH entries (default 4), sent and unsent together. vc_full_o[v] is then high, and a push to it is discarded and changes nothing.
- R11: After reset out_valid_o is low, all queues are empty, vc_full_o is 0 and every drop and retransmit count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Descriptor push strobe |
| in_vc_i | input | 4 | Target channel of the push |
| in_desc_i | input | 16 | Descriptor to enqueue |
| credit_ret_i | input | 9 | One credit returned per set bit |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vc_i | input | 4 | Channel being acknowledged |
| retry_i | input | 1 | Retry strobe |
| retry_vc_i | input | 4 | Channel being retried |
| cont_mode_i | input | 9 | Per-channel class: 1 continuous, 0 reliable (bit 0 ignored) |
| weight_i | input | 36 | Per-channel weight, 4 bits per channel |
| link_ready_i | input | 1 | Link accepts a packet this cycle |
| out_valid_o | output | 1 | Granted descriptor valid |
| out_vc_o | output | 4 | Channel of the granted descriptor |
| out_desc_o | output | 16 | Granted descriptor |
| vc_full_o | output | 9 | Per-channel queue full |
| drop_cnt_o | output | 72 | Per-channel drop count, 8 bits per channel |
| retx_cnt_o | output | 72 | Per-channel retransmit-event count, 8 bits per channel |

## Verification
Several properties are checked on every cycle. At most one channel is granted, and only one that has both a waiting entry and a credit. A credit is never taken from an empty counter. The scheduler's run length stays below the channel's weight. Sent entries never exceed queued entries. A push to a full continuous queue always steps its drop count. A channel under retry is never granted in that cycle. Only the bench scenarios can show the order in which packets leave: arrival order within a channel, the weighted rotation across channels, re-presentation after a retry, the survivors of a replacement on a continuous queue, and a grant resuming after a credit returns.

// File: rtl/vc_arb_pkg.sv
package vc_arb_pkg;
  localparam int unsigned VC_NUM     = 9;
  localparam int unsigned VC_DEPTH   = 4;
  localparam int unsigned VC_DESC_W  = 16;
  localparam int unsigned VC_CRED_W  = 4;
  localparam int unsigned VC_WT_W    = 4;
  localparam int unsigned VC_CNT_W   = 8;
endpackage

// File: rtl/vc_credit.sv
module vc_credit #(
  parameter int CRED_W = 4,
  parameter int INIT   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ret_i,
  input  logic take_i,
  output logic avail_o
);
  localparam logic [CRED_W-1:0] CMAX = '1;

  logic [CRED_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CRED_W'(INIT);
    else begin
      case ({ret_i, take_i})
        2'b10:   if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign avail_o = (cnt_q != '0);

  p_take_has_credit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (cnt_q != '0));
  p_credit_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !take_i && cnt_q == CMAX) |=> (cnt_q == CMAX));
endmodule

// File: rtl/vc_queue.sv
// Per-channel descriptor ring. DEPTH must be a power of two.
module vc_queue #(
  parameter int DEPTH  = 4,
  parameter int DESC_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cont_i,
  input  logic              push_i,
  input  logic [DESC_W-1:0] push_desc_i,
  input  logic              send_i,
  input  logic              ack_i,
  input  logic              retry_i,
  output logic              pend_o,
  output logic              full_o,
  output logic [DESC_W-1:0] head_desc_o,
  output logic [CNT_W-1:0]  drop_cnt_o,
  output logic [CNT_W-1:0]  retx_cnt_o
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_QW = $clog2(DEPTH + 1);

  logic [DESC_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q, send_ptr;
  logic [CNT_QW-1:0] count_q, sent_q;
  logic [CNT_W-1:0]  drop_q, retx_q;
  logic              ack_ok, rewind, drop_evt, push_ok, head_adv, cnt_inc, cnt_dec;

  assign full_o   = (count_q == CNT_QW'(DEPTH));
  assign pend_o   = (count_q > sent_q);
  assign send_ptr = head_q + PTR_W'(sent_q);
  assign head_desc_o = mem_q[send_ptr];

  assign ack_ok   = ack_i   && !cont_i && (sent_q != '0);
  assign rewind   = retry_i && !cont_i && (sent_q != '0);
  assign drop_evt = cont_i && push_i && full_o && !send_i;
  assign push_ok  = push_i && (cont_i || !full_o);
  assign head_adv = cont_i ? (send_i || drop_evt) : ack_ok;
  assign cnt_inc  = push_ok && !drop_evt;
  assign cnt_dec  = cont_i ? send_i : ack_ok;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[tail_q] <= push_desc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      sent_q  <= '0;
      drop_q  <= '0;
      retx_q  <= '0;
    end else begin
      if (push_ok)  tail_q <= tail_q + 1'b1;
      if (head_adv) head_q <= head_q + 1'b1;
      count_q <= count_q + CNT_QW'(cnt_inc) - CNT_QW'(cnt_dec);
      if (cont_i || rewind) sent_q <= '0;
      else sent_q <= sent_q + CNT_QW'(send_i) - CNT_QW'(ack_ok);
      if (drop_evt) drop_q <= drop_q + 1'b1;
      if (rewind)   retx_q <= retx_q + 1'b1;
    end
  end

  assign drop_cnt_o = drop_q;
  assign retx_cnt_o = retx_q;

  p_sent_within_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q <= count_q);
  p_send_needs_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i |-> pend_o);
  p_drop_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cont_i && full_o && !send_i) |=> (drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1)));
  p_reliable_full_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_i && full_o && !ack_i) |=> full_o);
  p_cont_no_retx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_i |=> $stable(retx_cnt_o));
endmodule

// File: rtl/vc_wrr_sched.sv
module vc_wrr_sched #(
  parameter int NUM  = 9,
  parameter int WT_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM-1:0]              elig_i,
  input  logic [NUM*WT_W-1:0]         weight_i,
  input  logic                        advance_i,
  output logic [NUM-1:0]              grant_o,
  output logic                        grant_v_o,
  output logic [$clog2(NUM)-1:0]      grant_idx_o
);
  localparam int IDX_W = $clog2(NUM);

  logic [WT_W-1:0]  wt_eff [NUM];
  logic [IDX_W-1:0] cur_q, win, win_next;
  logic [WT_W-1:0]  served_q, served_n;
  logic             found;

  for (genvar g = 0; g < NUM; g++) begin : g_wt
    logic [WT_W-1:0] w_raw;
    assign w_raw     = weight_i[g*WT_W +: WT_W];
    assign wt_eff[g] = (w_raw == '0) ? WT_W'(1) : w_raw;
  end

  always_comb begin
    found = 1'b0;
    win   = cur_q;
    for (int k = 0; k < NUM; k++) begin
      int idx;
      idx = int'(cur_q) + k;
      if (idx >= NUM) idx = idx - NUM;
      if (!found && elig_i[IDX_W'(idx)]) begin
        found = 1'b1;
        win   = IDX_W'(idx);
      end
    end
  end

  assign served_n  = (win == cur_q) ? served_q + 1'b1 : WT_W'(1);
  assign win_next  = (win == IDX_W'(NUM - 1)) ? '0 : win + 1'b1;
  assign grant_v_o = advance_i && found;
  assign grant_idx_o = win;

  always_comb begin
    grant_o = '0;
    if (grant_v_o) grant_o[win] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      served_q <= '0;
    end else if (grant_v_o) begin
      if (served_n == wt_eff[win]) begin
        cur_q    <= win_next;
        served_q <= '0;
      end else begin
        cur_q    <= win;
        served_q <= served_n;
      end
    end
  end

  p_run_below_weight_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    served_q < wt_eff[cur_q]);
  p_ptr_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q < IDX_W'(NUM));
endmodule

// File: rtl/vc_tx_arbiter.sv
module vc_tx_arbiter
  import vc_arb_pkg::*;
#(
  parameter int NUM_VC      = VC_NUM,
  parameter int DEPTH       = VC_DEPTH,
  parameter int DESC_W      = VC_DESC_W,
  parameter int CRED_W      = VC_CRED_W,
  parameter int INIT_CREDIT = 4,
  parameter int WT_W        = VC_WT_W,
  parameter int CNT_W       = VC_CNT_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [$clog2(NUM_VC)-1:0]   in_vc_i,
  input  logic [DESC_W-1:0]           in_desc_i,
  input  logic [NUM_VC-1:0]           credit_ret_i,
  input  logic                        ack_i,
  input  logic [$clog2(NUM_VC)-1:0]   ack_vc_i,
  input  logic                        retry_i,
  input  logic [$clog2(NUM_VC)-1:0]   retry_vc_i,
  input  logic [NUM_VC-1:0]           cont_mode_i,
  input  logic [NUM_VC*WT_W-1:0]      weight_i,
  input  logic                        link_ready_i,
  output logic                        out_valid_o,
  output logic [$clog2(NUM_VC)-1:0]   out_vc_o,
  output logic [DESC_W-1:0]           out_desc_o,
  output logic [NUM_VC-1:0]           vc_full_o,
  output logic [NUM_VC*CNT_W-1:0]     drop_cnt_o,
  output logic [NUM_VC*CNT_W-1:0]     retx_cnt_o
);
  localparam int IDX_W = $clog2(NUM_VC);

  logic [NUM_VC-1:0] q_pend, cr_avail, elig, grant, cls_cont, retry_hit;
  logic [DESC_W-1:0] head_desc [NUM_VC];
  logic              grant_v;
  logic [IDX_W-1:0]  grant_idx;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    // channel 0 is hard-wired reliable
    if (v == 0) begin : g_fixed
      assign cls_cont[v] = 1'b0;
    end else begin : g_cfg
      assign cls_cont[v] = cont_mode_i[v];
    end

    assign retry_hit[v] = retry_i && (retry_vc_i == IDX_W'(v)) && !cls_cont[v];
    assign elig[v]      = q_pend[v] && cr_avail[v] && !retry_hit[v];

    vc_queue #(
      .DEPTH (DEPTH),
      .DESC_W(DESC_W),
      .CNT_W (CNT_W)
    ) u_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cont_i      (cls_cont[v]),
      .push_i      (in_valid_i && (in_vc_i == IDX_W'(v))),
      .push_desc_i (in_desc_i),
      .send_i      (grant[v]),
      .ack_i       (ack_i && (ack_vc_i == IDX_W'(v))),
      .retry_i     (retry_i && (retry_vc_i == IDX_W'(v))),
      .pend_o      (q_pend[v]),
      .full_o      (vc_full_o[v]),
      .head_desc_o (head_desc[v]),
      .drop_cnt_o  (drop_cnt_o[v*CNT_W +: CNT_W]),
      .retx_cnt_o  (retx_cnt_o[v*CNT_W +: CNT_W])
    );

    vc_credit #(
      .CRED_W(CRED_W),
      .INIT  (INIT_CREDIT)
    ) u_credit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ret_i  (credit_ret_i[v]),
      .take_i (grant[v]),
      .avail_o(cr_avail[v])
    );

    p_grant_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant[v] |-> (q_pend[v] && cr_avail[v]));
    p_retry_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      retry_hit[v] |-> !grant[v]);
  end

  vc_wrr_sched #(
    .NUM (NUM_VC),
    .WT_W(WT_W)
  ) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .elig_i     (elig),
    .weight_i   (weight_i),
    .advance_i  (link_ready_i),
    .grant_o    (grant),
    .grant_v_o  (grant_v),
    .grant_idx_o(grant_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_vc_o    <= '0;
      out_desc_o  <= '0;
    end else begin
      out_valid_o <= grant_v;
      if (grant_v) begin
        out_vc_o   <= grant_idx;
        out_desc_o <= head_desc[grant_idx];
      end
    end
  end

  p_single_grant_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  p_idle_link_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ready_i |=> !out_valid_o);
  p_out_vc_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_vc_o < IDX_W'(NUM_VC)));
endmodule

// File: tb/vc_tx_arbiter_tb_top.sv
`timescale 1ns/1ps
module vc_tx_arbiter_tb_top;
  localparam int NV = 9;
  localparam int CW = 8;

  typedef struct packed {
    logic        push;
    logic [3:0]  vc;
    logic [15:0] desc;
    logic        rdy;
    logic        ack;
    logic        retry;
    logic [3:0]  avc;
    logic        ev;
    logic [3:0]  evc;
    logic [15:0] ed;
    logic [3:0]  req;
  } step_t;

  // weights: vc0 = 0 (acts as 1), vc1 = 2, rest 1; all channels reliable
  localparam int NSTEP = 15;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 4'd0, 16'h00A0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd1},  // R1 fill
    '{1'b1, 4'd0, 16'h00A1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd1},
    '{1'b1, 4'd1, 16'h00B0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd1},
    '{1'b1, 4'd1, 16'h00B1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd1},
    '{1'b1, 4'd1, 16'h00B2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd2},  // R2 link idle
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0, 16'h00A0, 4'd4},  // R4 weight 0 as 1
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd1, 16'h00B0, 4'd4},
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd1, 16'h00B1, 4'd4},  // R4 second of run
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0, 16'h00A1, 4'd1},  // R1 wrap, order
    '{1'b0, 4'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd7},  // R7 retry ch0
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd1, 16'h00B2, 4'd4},
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0, 16'h00A0, 4'd7},  // R7 oldest first
    '{1'b0, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd6},  // R6 ack
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd0, 16'h00A1, 4'd7},
    '{1'b0, 4'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd3}   // R3 credits gone
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i;
  logic [3:0]        in_vc_i;
  logic [15:0]       in_desc_i;
  logic [NV-1:0]     credit_ret_i;
  logic              ack_i;
  logic [3:0]        ack_vc_i;
  logic              retry_i;
  logic [3:0]        retry_vc_i;
  logic [NV-1:0]     cont_mode_i;
  logic [NV*4-1:0]   weight_i;
  logic              link_ready_i;
  logic              out_valid_o;
  logic [3:0]        out_vc_o;
  logic [15:0]       out_desc_o;
  logic [NV-1:0]     vc_full_o;
  logic [NV*CW-1:0]  drop_cnt_o;
  logic [NV*CW-1:0]  retx_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  vc_tx_arbiter dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_vc_i, .in_desc_i, .credit_ret_i,
    .ack_i, .ack_vc_i, .retry_i, .retry_vc_i, .cont_mode_i, .weight_i,
    .link_ready_i, .out_valid_o, .out_vc_o, .out_desc_o, .vc_full_o,
    .drop_cnt_o, .retx_cnt_o
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid_i   = 1'b0;
    in_vc_i      = '0;
    in_desc_i    = '0;
    credit_ret_i = '0;
    ack_i        = 1'b0;
    ack_vc_i     = '0;
    retry_i      = 1'b0;
    retry_vc_i   = '0;
    link_ready_i = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic push(input logic [3:0] vc, input logic [15:0] d);
    in_valid_i = 1'b1; in_vc_i = vc; in_desc_i = d;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic ack_one(input logic [3:0] vc);
    ack_i = 1'b1; ack_vc_i = vc;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic grant_expect(string tag, input logic ev, input logic [3:0] vc,
                              input logic [15:0] d);
    link_ready_i = 1'b1;
    @(negedge clk_i);
    link_ready_i = 1'b0;
    if (ev) check(tag, {11'd0, out_valid_o, out_vc_o, out_desc_o}, {11'd0, 1'b1, vc, d});
    else    check(tag, {31'd0, out_valid_o}, 32'd0);
  endtask

  function automatic logic [CW-1:0] fld(input logic [NV*CW-1:0] bus, input int v);
    return bus[v*CW +: CW];
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    cont_mode_i = '0;
    weight_i    = '0;
    for (int v = 0; v < NV; v++) weight_i[v*4 +: 4] = 4'd1;
    weight_i[3:0] = 4'd0;
    weight_i[7:4] = 4'd2;
    do_reset();

    // R11 reset state
    check("R11 out_valid", {31'd0, out_valid_o}, 32'd0);
    check("R11 vc_full", {23'd0, vc_full_o}, 32'd0);
    check("R11 counters", {31'd0, (drop_cnt_o == '0 && retx_cnt_o == '0)}, 32'd1);

    // vector walk: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < NSTEP; i++) begin
      in_valid_i   = STEPS[i].push;
      in_vc_i      = STEPS[i].vc;
      in_desc_i    = STEPS[i].desc;
      link_ready_i = STEPS[i].rdy;
      ack_i        = STEPS[i].ack;
      ack_vc_i     = STEPS[i].avc;
      retry_i      = STEPS[i].retry;
      retry_vc_i   = STEPS[i].avc;
      @(negedge clk_i);
      if (STEPS[i].ev)
        check($sformatf("R%0d step %0d", STEPS[i].req, i),
              {11'd0, out_valid_o, out_vc_o, out_desc_o},
              {11'd0, 1'b1, STEPS[i].evc, STEPS[i].ed});
      else
        check($sformatf("R%0d step %0d", STEPS[i].req, i), {31'd0, out_valid_o}, 32'd0);
    end
    idle_inputs();
    check("R7 retx count ch0", {24'd0, fld(retx_cnt_o, 0)}, 32'd1);
    check("R7 retx count ch1", {24'd0, fld(retx_cnt_o, 1)}, 32'd0);

    // R8 R9: continuous channel 2 overflow
    cont_mode_i = 9'b0_0000_0100;
    do_reset();
    for (int k = 0; k < 4; k++) push(4'd2, 16'h00D0 + 16'(k));
    check("R9 full after four", {31'd0, vc_full_o[2]}, 32'd1);
    push(4'd2, 16'h00D4);
    check("R9 drop count", {24'd0, fld(drop_cnt_o, 2)}, 32'd1);
    retry_i = 1'b1; retry_vc_i = 4'd2; ack_i = 1'b1; ack_vc_i = 4'd2;
    @(negedge clk_i);
    idle_inputs();
    check("R8 retry ignored", {24'd0, fld(retx_cnt_o, 2)}, 32'd0);
    for (int k = 1; k < 5; k++)
      grant_expect("R9 survivor order", 1'b1, 4'd2, 16'h00D0 + 16'(k));
    grant_expect("R8 removed on send", 1'b0, 4'd0, 16'h0);
    check("R8 not full after drain", {31'd0, vc_full_o[2]}, 32'd0);

    // R10 R3 R6: reliable channel 3 full, credit exhaustion and return
    do_reset();
    for (int k = 0; k < 5; k++) push(4'd3, 16'h00F0 + 16'(k));
    check("R10 full flag", {31'd0, vc_full_o[3]}, 32'd1);
    for (int k = 0; k < 4; k++)
      grant_expect("R10 kept entries", 1'b1, 4'd3, 16'h00F0 + 16'(k));
    grant_expect("R10 fifth discarded", 1'b0, 4'd0, 16'h0);
    check("R6 still full while unacked", {31'd0, vc_full_o[3]}, 32'd1);
    for (int k = 0; k < 4; k++) ack_one(4'd3);
    check("R6 acks free entries", {31'd0, vc_full_o[3]}, 32'd0);
    ack_one(4'd3);
    push(4'd3, 16'h00F9);
    grant_expect("R3 no credit no grant", 1'b0, 4'd0, 16'h0);
    credit_ret_i = 9'b0_0000_1000;
    @(negedge clk_i);
    credit_ret_i = '0;
    grant_expect("R3 grant after credit", 1'b1, 4'd3, 16'h00F9);

    // R5: channel 0 stays reliable with its mode bit set
    cont_mode_i = '1;
    do_reset();
    for (int k = 0; k < 5; k++) push(4'd0, 16'h0C00 + 16'(k));
    check("R5 ch0 no drop", {24'd0, fld(drop_cnt_o, 0)}, 32'd0);
    check("R5 ch0 full", {31'd0, vc_full_o[0]}, 32'd1);
    grant_expect("R5 ch0 oldest kept", 1'b1, 4'd0, 16'h0C00);

    done = 1'b1;
    finish_run();
  end
endmodule